// File: doc/BRIEF.md
# Triggered Rectifying Result Integrator

This stage post-processes the stream of decimated filter results in a sigma-delta conversion channel. Each incoming result may first be rectified: it is negated whenever a sign reference marks the negative half-wave of an excitation carrier. That reference is produced by an internal square-wave generator that advances once per filter result, or it is taken from an external sign input. The reference passes through a delay, counted in filter results, that lines it up with the filter's group delay.

The rectified values then feed a triggered integrator. A selectable trigger edge clears the sequence and emits a pulse that clears the upstream filter. A programmed number of results is dropped, and then groups of up to 64 results are summed. Each sum is published as the sum shifted right by six bits, with a one-cycle valid pulse. In fixed-window mode this repeats a programmed number of times. In variable-window mode it repeats until the trigger returns to its idle level. Either stage can be bypassed, and with the integrator bypassed every result goes straight to the output.

Top module: `rii_top`

## Requirements
- R1: With `cfg_integ_en`=0, every result presented with `smp_valid` appears on `res_data` with `res_valid` high in the next cycle. With `cfg_rect_en`=0 the value is unchanged.
- R2: With `cfg_rect_en`=1 and the applied sign reference at 1 (negative half-wave), the result is two's-complement negated. The most negative value, -32768, becomes +32767.
- R3: The internal sign generator reads 0 after reset and inverts after every `cfg_half_m1`+1 filter results. It does not change in cycles without `smp_valid`.
- R4: The sign applied to a result is the raw reference from `cfg_sign_dly` results earlier, or 0 if fewer results have arrived since reset. The raw reference is `sign_ext` (sampled with each result) when `cfg_sign_ext_sel`=1, and the generator otherwise.
- R5: With `cfg_integ_en`=1, a start edge begins a new sequence. The start edge is rising when `cfg_trig_fall`=0 and falling when it is 1. The start edge clears the sum, the counters and the loop count, and it drives `filt_clear` high for exactly the next cycle. A result that arrives in the cycle of the edge is ignored.
- R6: After a start edge, the first `cfg_discard` results are dropped before summing begins.
- R7: Each published value is the sum of `cfg_sum_m1`+1 rectified results, shifted arithmetically right by 6 (sum bits [21:6]) whatever the count. `res_valid` is high in the cycle after the last summed result.
- R8: With `cfg_var_win`=0, exactly `cfg_loops_m1`+1 values are published per start edge, and the end of the trigger level has no effect.
- R9: With `cfg_var_win`=1, summing repeats until the closing edge. The closing edge is the opposite of the start edge. It drops any partial sum and publishes nothing more, and `res_data` keeps the last complete value.
- R10: Sums of 64 full-scale results never overflow: 64 × 32767 publishes 32767, and 64 × -32768 publishes -32768.
- R11: After reset `res_data` is 0, and `res_valid` and `filt_clear` are low. With integration on and no start edge, `res_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Filter result strobe |
| smp_data | input | 16 | Filter result, two's complement |
| trig_in | input | 1 | Trigger level |
| sign_ext | input | 1 | External sign reference, 1 = negative half-wave |
| cfg_trig_fall | input | 1 | 0: rising start edge, 1: falling start edge |
| cfg_var_win | input | 1 | 0: fixed loop count, 1: window bounded by trigger |
| cfg_integ_en | input | 1 | 1: integrate, 0: pass results through |
| cfg_rect_en | input | 1 | 1: apply rectification |
| cfg_sign_ext_sel | input | 1 | 1: external sign, 0: internal generator |
| cfg_sign_dly | input | 4 | Sign delay in filter results (0..15) |
| cfg_half_m1 | input | 8 | Generator half-period in results, minus one |
| cfg_discard | input | 8 | Results dropped after a start edge |
| cfg_sum_m1 | input | 6 | Results per sum, minus one |
| cfg_loops_m1 | input | 8 | Fixed-mode published values, minus one |
| res_data | output | 16 | Published value |
| res_valid | output | 1 | One-cycle publish strobe |
| filt_clear | output | 1 | One-cycle clear request for the upstream filter |

## Verification
The bench builds the block with its default parameters: 16-bit data, a 4-bit sign delay reaching back 15 results, an 8-bit half-period, discard and loop count, and a 6-bit sum count. This keeps every delay tap and the full 64-result sum inside a short run. Under these values a full-scale sum and the saturation of the negated minimum are both reachable. Short half-periods (one to eight results) make the generator toggle many times in each scenario. Small discard and sum counts let the bench cover several fixed-mode loops, retriggers and variable-window closures.

// File: rtl/rii_pkg.sv
package rii_pkg;

    localparam int DATA_W   = 16;
    localparam int SCALE_SH = 6;
    localparam int ACC_W    = DATA_W + SCALE_SH;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DISCARD = 2'd1,
        ST_INTEG   = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic start;
        logic stop;
    } trig_evt_t;

endpackage

// File: rtl/rii_carrier_sign.sv
module rii_carrier_sign #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [HALF_W-1:0] half_m1,
    output logic              sgn
);

    logic [HALF_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sgn   <= 1'b0;
        end else if (adv) begin
            if (cnt_q == half_m1) begin
                cnt_q <= '0;
                sgn   <= ~sgn;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: the carrier sign only moves on a filter result
    a_r3_sign_steady: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(sgn));

endmodule

// File: rtl/rii_sign_align.sv
module rii_sign_align #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             ext_sel,
    input  logic             ext_sign,
    input  logic             gen_sign,
    input  logic [DLY_W-1:0] dly,
    output logic             sign_out
);

    localparam int HIST_N = (1 << DLY_W) - 1;

    logic              raw;
    logic [HIST_N-1:0] hist_q;

    assign raw = ext_sel ? ext_sign : gen_sign;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (adv) begin
            hist_q <= {hist_q[HIST_N-2:0], raw};
        end
    end

    always_comb begin
        if (dly == '0) begin
            sign_out = raw;
        end else begin
            sign_out = hist_q[dly - 1'b1];
        end
    end

    // R4: the newest history entry is the reference of the previous result
    a_r4_hist_shift: assert property (@(posedge clk) disable iff (rst)
        adv |=> hist_q[0] == $past(raw));

endmodule

// File: rtl/rii_rectify.sv
module rii_rectify #(
    parameter int DATA_W = 16
) (
    input  logic                     en,
    input  logic                     neg,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] dout
);

    localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

    always_comb begin
        if (en && neg) begin
            dout = (din == MIN_V) ? MAX_V : -din;
        end else begin
            dout = din;
        end
    end

endmodule

// File: rtl/rii_integ_seq.sv
module rii_integ_seq
    import rii_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int SH     = SCALE_SH,
    parameter int CNT_W  = 8,
    parameter int LOOP_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 integ_en,
    input  logic                 var_win,
    input  logic                 trig_fall,
    input  logic                 trig_in,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp_val,
    input  logic [CNT_W-1:0]     discard,
    input  logic [SH-1:0]        sum_m1,
    input  logic [LOOP_W-1:0]    loops_m1,
    output logic [DW-1:0]        res_data,
    output logic                 res_valid,
    output logic                 filt_clear
);

    localparam int AW = DW + SH;

    logic                 trig_q;
    trig_evt_t            evt;
    seq_state_t           st_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [LOOP_W-1:0]    rep_q;
    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] sum_w;
    logic                 last_sum;

    always_comb begin
        evt.start = trig_fall ? (!trig_in && trig_q) : (trig_in && !trig_q);
        evt.stop  = trig_fall ? (trig_in && !trig_q) : (!trig_in && trig_q);
    end

    assign sum_w    = acc_q + {{SH{smp_val[DW-1]}}, smp_val};
    assign last_sum = (cnt_q == CNT_W'(sum_m1));

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q     <= 1'b0;
            st_q       <= ST_IDLE;
            cnt_q      <= '0;
            rep_q      <= '0;
            acc_q      <= '0;
            res_data   <= '0;
            res_valid  <= 1'b0;
            filt_clear <= 1'b0;
        end else begin
            trig_q     <= trig_in;
            res_valid  <= 1'b0;
            filt_clear <= 1'b0;
            if (!integ_en) begin
                st_q <= ST_IDLE;
                if (smp_valid) begin
                    res_valid <= 1'b1;
                    res_data  <= smp_val;
                end
            end else if (evt.start) begin
                filt_clear <= 1'b1;
                st_q       <= (discard == '0) ? ST_INTEG : ST_DISCARD;
                cnt_q      <= '0;
                acc_q      <= '0;
                rep_q      <= '0;
            end else if (evt.stop && var_win && st_q != ST_IDLE) begin
                st_q  <= ST_IDLE;
                cnt_q <= '0;
                acc_q <= '0;
            end else if (smp_valid) begin
                case (st_q)
                    ST_DISCARD: begin
                        if (cnt_q == discard - 1'b1) begin
                            st_q  <= ST_INTEG;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_INTEG: begin
                        if (last_sum) begin
                            res_valid <= 1'b1;
                            res_data  <= sum_w[AW-1:SH];
                            acc_q     <= '0;
                            cnt_q     <= '0;
                            rep_q     <= rep_q + 1'b1;
                            if (!var_win && rep_q == loops_m1) begin
                                st_q <= ST_IDLE;
                            end
                        end else begin
                            acc_q <= sum_w;
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5: the filter clear request is a single-cycle pulse
    a_r5_clear_pulse: assert property (@(posedge clk) disable iff (rst)
        filt_clear |=> !filt_clear);

    // R5: a clear request coincides with an emptied sum and count
    a_r5_clear_state: assert property (@(posedge clk) disable iff (rst)
        filt_clear |-> (acc_q == '0) && (cnt_q == '0));

    // R7: an integrated value is only published out of the summing state
    a_r7_publish_src: assert property (@(posedge clk) disable iff (rst)
        res_valid && $past(integ_en) |-> ($past(st_q) == ST_INTEG) && $past(smp_valid));

    // R11: an idle sequencer stays quiet unless a start edge arrives
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        integ_en && st_q == ST_IDLE && !evt.start |=> !res_valid);

    // R9: closing the window idles the sequencer and keeps the last value
    a_r9_close_hold: assert property (@(posedge clk) disable iff (rst)
        integ_en && var_win && evt.stop && st_q != ST_IDLE
        |=> (st_q == ST_IDLE) && $stable(res_data));

endmodule

// File: rtl/rii_top.sv
module rii_top
    import rii_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int DLY_W  = 4,
    parameter int HALF_W = 8,
    parameter int CNT_W  = 8,
    parameter int SUM_W  = SCALE_SH,
    parameter int LOOP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [DW-1:0]     smp_data,
    input  logic              trig_in,
    input  logic              sign_ext,
    input  logic              cfg_trig_fall,
    input  logic              cfg_var_win,
    input  logic              cfg_integ_en,
    input  logic              cfg_rect_en,
    input  logic              cfg_sign_ext_sel,
    input  logic [DLY_W-1:0]  cfg_sign_dly,
    input  logic [HALF_W-1:0] cfg_half_m1,
    input  logic [CNT_W-1:0]  cfg_discard,
    input  logic [SUM_W-1:0]  cfg_sum_m1,
    input  logic [LOOP_W-1:0] cfg_loops_m1,
    output logic [DW-1:0]     res_data,
    output logic              res_valid,
    output logic              filt_clear
);

    logic                 gen_sign;
    logic                 rect_neg;
    logic signed [DW-1:0] rect_out;

    rii_carrier_sign #(.HALF_W(HALF_W)) u_carrier (
        .clk     (clk),
        .rst     (rst),
        .adv     (smp_valid),
        .half_m1 (cfg_half_m1),
        .sgn     (gen_sign)
    );

    rii_sign_align #(.DLY_W(DLY_W)) u_align (
        .clk      (clk),
        .rst      (rst),
        .adv      (smp_valid),
        .ext_sel  (cfg_sign_ext_sel),
        .ext_sign (sign_ext),
        .gen_sign (gen_sign),
        .dly      (cfg_sign_dly),
        .sign_out (rect_neg)
    );

    rii_rectify #(.DATA_W(DW)) u_rect (
        .en   (cfg_rect_en),
        .neg  (rect_neg),
        .din  ($signed(smp_data)),
        .dout (rect_out)
    );

    rii_integ_seq #(
        .DW     (DW),
        .SH     (SUM_W),
        .CNT_W  (CNT_W),
        .LOOP_W (LOOP_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .integ_en   (cfg_integ_en),
        .var_win    (cfg_var_win),
        .trig_fall  (cfg_trig_fall),
        .trig_in    (trig_in),
        .smp_valid  (smp_valid),
        .smp_val    (rect_out),
        .discard    (cfg_discard),
        .sum_m1     (cfg_sum_m1),
        .loops_m1   (cfg_loops_m1),
        .res_data   (res_data),
        .res_valid  (res_valid),
        .filt_clear (filt_clear)
    );

    // R2: a negated negative input never comes out negative
    a_r2_rect_sign: assert property (@(posedge clk) disable iff (rst)
        cfg_rect_en && rect_neg && smp_data[DW-1] |-> !rect_out[DW-1]);

endmodule

// File: tb/rii_top_bench.sv
module rii_top_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        trig_in = 1'b0;
    logic        sign_ext = 1'b0;
    logic        cfg_trig_fall = 1'b0;
    logic        cfg_var_win = 1'b0;
    logic        cfg_integ_en = 1'b0;
    logic        cfg_rect_en = 1'b0;
    logic        cfg_sign_ext_sel = 1'b0;
    logic [3:0]  cfg_sign_dly = '0;
    logic [7:0]  cfg_half_m1 = '0;
    logic [7:0]  cfg_discard = '0;
    logic [5:0]  cfg_sum_m1 = '0;
    logic [7:0]  cfg_loops_m1 = '0;
    logic [15:0] res_data;
    logic        res_valid;
    logic        filt_clear;

    rii_top u_rii_top (
        .clk              (clk),
        .rst              (rst),
        .smp_valid        (smp_valid),
        .smp_data         (smp_data),
        .trig_in          (trig_in),
        .sign_ext         (sign_ext),
        .cfg_trig_fall    (cfg_trig_fall),
        .cfg_var_win      (cfg_var_win),
        .cfg_integ_en     (cfg_integ_en),
        .cfg_rect_en      (cfg_rect_en),
        .cfg_sign_ext_sel (cfg_sign_ext_sel),
        .cfg_sign_dly     (cfg_sign_dly),
        .cfg_half_m1      (cfg_half_m1),
        .cfg_discard      (cfg_discard),
        .cfg_sum_m1       (cfg_sum_m1),
        .cfg_loops_m1     (cfg_loops_m1),
        .res_data         (res_data),
        .res_valid        (res_valid),
        .filt_clear       (filt_clear)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    int    n_out = 0;
    bit    done = 1'b0;
    string tag = "R11";

    // expectation state derived from the requirements
    int          m_hc, m_st, m_cnt, m_rep;
    bit          m_sgn, m_trq;
    logic [14:0] m_hist;
    longint      m_acc;
    int          exp_data;
    bit          exp_valid, exp_clr;

    task automatic check(string rq, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", rq, act, expv);
        end
    endtask

    task automatic model_reset();
        m_hc = 0; m_sgn = 0; m_hist = '0; m_trq = 0;
        m_st = 0; m_cnt = 0; m_rep = 0; m_acc = 0;
        exp_data = 0; exp_valid = 0; exp_clr = 0;
    endtask

    task automatic model_cycle();
        bit raw, sg, st, sp;
        int v;
        raw = cfg_sign_ext_sel ? sign_ext : m_sgn;
        if (cfg_sign_dly == 0) sg = raw;
        else sg = m_hist[int'(cfg_sign_dly) - 1];
        v = int'($signed(smp_data));
        if (cfg_rect_en && sg) v = (v == -32768) ? 32767 : -v;
        if (smp_valid) begin
            m_hist = {m_hist[13:0], raw};
            if (m_hc == int'(cfg_half_m1)) begin m_hc = 0; m_sgn = ~m_sgn; end
            else m_hc++;
        end
        st = cfg_trig_fall ? (!trig_in && m_trq) : (trig_in && !m_trq);
        sp = cfg_trig_fall ? (trig_in && !m_trq) : (!trig_in && m_trq);
        m_trq = trig_in;
        exp_valid = 0;
        exp_clr = 0;
        if (!cfg_integ_en) begin
            m_st = 0;
            if (smp_valid) begin exp_valid = 1; exp_data = v; end
        end else if (st) begin
            exp_clr = 1;
            m_st = (cfg_discard == 0) ? 2 : 1;
            m_cnt = 0; m_acc = 0; m_rep = 0;
        end else if (sp && cfg_var_win && m_st != 0) begin
            m_st = 0; m_cnt = 0; m_acc = 0;
        end else if (smp_valid) begin
            if (m_st == 1) begin
                m_cnt++;
                if (m_cnt == int'(cfg_discard)) begin m_st = 2; m_cnt = 0; end
            end else if (m_st == 2) begin
                m_acc += v;
                m_cnt++;
                if (m_cnt == int'(cfg_sum_m1) + 1) begin
                    exp_valid = 1;
                    exp_data = int'(m_acc >>> 6);
                    m_acc = 0; m_cnt = 0; m_rep++;
                    if (!cfg_var_win && m_rep == int'(cfg_loops_m1) + 1) m_st = 0;
                end
            end
        end
    endtask

    task automatic step(bit v, int d, bit t, bit e);
        smp_valid = v;
        smp_data = 16'(d);
        trig_in = t;
        sign_ext = e;
        model_cycle();
        @(negedge clk);
        check({tag, " res_valid"}, int'(res_valid), int'(exp_valid));
        check({tag, " res_data"}, int'($signed(res_data)), exp_data);
        check({tag, " filt_clear"}, int'(filt_clear), int'(exp_clr));
        if (res_valid) n_out++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_valid = 0; smp_data = '0; trig_in = 0; sign_ext = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        n_out = 0;
    endtask

    function automatic int rnd16();
        return int'($signed(16'($urandom)));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));

        // R11: reset state
        do_reset();
        check("R11 reset res_valid", int'(res_valid), 0);
        check("R11 reset res_data", int'(res_data), 0);
        check("R11 reset filt_clear", int'(filt_clear), 0);

        // R1: full bypass, random sparse stream
        tag = "R1";
        for (int i = 0; i < 60; i++) step(1'($urandom), rnd16(), 1'($urandom), 1'b0);

        // R2 / R3: rectification with the internal generator
        cfg_rect_en = 1; cfg_half_m1 = 8'd0;
        do_reset();
        tag = "R2";
        step(1, 100, 0, 0);
        check("R2 sign 0 keeps value", int'($signed(res_data)), 100);
        step(1, -32768, 0, 0);
        check("R2 saturated negation", int'($signed(res_data)), 32767);
        tag = "R3";
        cfg_half_m1 = 8'd3;
        do_reset();
        for (int i = 0; i < 80; i++) step(1'($urandom), rnd16(), 0, 0);

        // R4: delayed internal sign, then delayed external sign
        tag = "R4";
        cfg_half_m1 = 8'd4; cfg_sign_dly = 4'd3;
        do_reset();
        for (int i = 0; i < 80; i++) step(1'($urandom), rnd16(), 0, 0);
        cfg_sign_ext_sel = 1; cfg_sign_dly = 4'd2;
        do_reset();
        for (int i = 0; i < 60; i++) step(1, rnd16(), 0, 1'($urandom));
        cfg_sign_dly = 4'd15;
        do_reset();
        for (int i = 0; i < 40; i++) step(1, rnd16(), 0, 1'($urandom));
        cfg_sign_ext_sel = 0; cfg_sign_dly = 4'd0; cfg_rect_en = 0;

        // R11: integration on, no trigger edge
        tag = "R11";
        cfg_integ_en = 1;
        do_reset();
        for (int i = 0; i < 30; i++) step(1, rnd16(), 0, 0);
        check("R11 no output without edge", n_out, 0);

        // R6 / R7 / R8: fixed window, rising edge
        tag = "R8";
        cfg_discard = 8'd3; cfg_sum_m1 = 6'd3; cfg_loops_m1 = 8'd1;
        do_reset();
        step(0, 0, 1, 0);
        for (int i = 0; i < 40; i++) step(1, rnd16(), (i < 3), 0);
        check("R8 fixed loop count", n_out, 2);
        tag = "R5";
        n_out = 0;
        step(1, rnd16(), 1, 0);
        for (int i = 0; i < 40; i++) step(1'($urandom), rnd16(), 1, 0);
        check("R5 retrigger publishes again", n_out, 2);

        // R5: falling start edge
        tag = "R5";
        cfg_trig_fall = 1; cfg_discard = 8'd0; cfg_sum_m1 = 6'd1; cfg_loops_m1 = 8'd2;
        do_reset();
        for (int i = 0; i < 3; i++) step(1, rnd16(), 1, 0);
        check("R5 rising ignored when falling selected", n_out, 0);
        step(1, 30000, 0, 0);
        for (int i = 0; i < 20; i++) step(1, rnd16(), 0, 0);
        check("R5 falling edge loop count", n_out, 3);

        // R9: variable window with rectification
        tag = "R9";
        begin
            int held;
            cfg_trig_fall = 0; cfg_var_win = 1; cfg_rect_en = 1; cfg_half_m1 = 8'd7;
            cfg_sign_dly = 4'd2; cfg_discard = 8'd2; cfg_sum_m1 = 6'd7;
            do_reset();
            for (int i = 0; i < 45; i++) step(1'($urandom) | (i < 12), rnd16(), 1, 0);
            held = int'($signed(res_data));
            n_out = 0;
            for (int i = 0; i < 20; i++) step(1, rnd16(), 0, 0);
            check("R9 no output after close", n_out, 0);
            check("R9 last value held", int'($signed(res_data)), held);
        end

        // R10 / R7: full-scale sums of 64 values
        tag = "R10";
        cfg_var_win = 0; cfg_rect_en = 0; cfg_sign_dly = 4'd0; cfg_discard = 8'd0;
        cfg_sum_m1 = 6'd63; cfg_loops_m1 = 8'd0;
        do_reset();
        step(0, 0, 1, 0);
        for (int i = 0; i < 64; i++) step(1, 32767, 1, 0);
        check("R10 positive full scale", int'($signed(res_data)), 32767);
        step(0, 0, 0, 0);
        step(0, 0, 1, 0);
        for (int i = 0; i < 64; i++) step(1, -32768, 1, 0);
        check("R10 negative full scale", int'($signed(res_data)), -32768);
        tag = "R7";
        cfg_sum_m1 = 6'd4; cfg_loops_m1 = 8'd5;
        do_reset();
        step(0, 0, 1, 0);
        for (int i = 0; i < 40; i++) step(1'($urandom), rnd16(), 1, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule